// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block turns one outgoing frame, supplied as a byte stream, into the serial bit sequence for a 10 Mb/s PHY. Each period of the bit-time enable is one bit time. A frame is announced by holding `inValid` high. The formatter then defers to the medium. It waits until carrier sense has been low for 60 consecutive bit times, then waits another 36 bit times without looking at carrier sense. After that it raises `txEn` and sends seven preamble bytes, the start-of-frame delimiter, and then the frame bytes as it pulls them from the stream.

Two flags arrive with the last byte of the frame. When the pad flag is set, a frame that is shorter than the programmable minimum is filled out with zero bytes. When the CRC flag is set, a 32-bit frame check sequence is appended after the last byte or pad byte. At the end of the frame `txEn` drops, so the PHY can mark the end of the frame, and `frameDone` pulses once. The byte source must offer the next byte whenever `inReady` asks for it. Collision recovery and descriptor handling belong to other blocks.

Top module: `eth_tx_formatter`

## Requirements
- R1: While reset is held, and after it is released with no frame offered, `txEn`, `txData`, `frameDone` and `inReady` are all 0.
- R2: A frame on the wire starts with seven bytes of 0x55 and then one byte of 0xD5, all sent while `txEn` is 1.
- R3: Every byte is sent least-significant bit first. The frame bytes follow the delimiter in the order in which the stream delivered them.
- R4: If carrier sense was high on bit tick T and stays low afterwards, the first preamble bit is driven on tick T+97: 60 quiet ticks, 36 hold ticks, then the first bit.
- R5: If carrier sense is high on any tick of the 60-tick quiet phase, the quiet count restarts from that tick.
- R6: Carrier sense is ignored during the 36-tick hold phase. A pulse there does not move the start of the frame.
- R7: When the pad flag of the last byte is 1 and fewer than `minLen` frame bytes were sent, zero bytes are added until `minLen` bytes have been sent. The FCS is not counted in `minLen`. Setting `minLen` to 60 gives a 46-byte minimum data field after the 14 header bytes.
- R8: When the pad flag is 0, or the frame already holds at least `minLen` bytes, no filler byte is sent.
- R9: When the CRC flag of the last byte is 1, 32 FCS bits follow the last frame or pad byte. The FCS is the complement of the CRC-32 over those bytes (reflected polynomial 0xEDB88320, preset all ones), sent bit 0 first. When the flag is 0, no FCS is sent.
- R10: `txEn` falls on the bit tick after the final bit. `frameDone` is high for exactly that one clock.
- R11: `inReady` is high only in a clock where `bitEn` is high. A byte is taken only when `inValid` and `inReady` are both 1.
- R12: `txEn` and `txData` change only on clocks where `bitEn` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-clock enable per bit time |
| inData | input | 8 | Frame byte offered by the source |
| inValid | input | 1 | Source has a byte, or a frame is pending |
| inReady | output | 1 | Byte taken in this clock |
| inLast | input | 1 | Offered byte is the last of the frame |
| inPad | input | 1 | Pad flag, taken with the last byte |
| inCrc | input | 1 | Append-FCS flag, taken with the last byte |
| carrierSense | input | 1 | Medium busy indication |
| minLen | input | LEN_W (11) | Minimum frame bytes, FCS excluded |
| txData | output | 1 | Serial bit to the PHY |
| txEn | output | 1 | Transmit enable to the PHY |
| frameDone | output | 1 | One-clock pulse when a frame ends |

## Verification
The hardest cases to reach from the ports are a carrier-sense pulse that lands inside the 60-tick quiet phase and one that lands inside the 36-tick hold phase. These two are indistinguishable unless the pulse hits a particular bit tick. The bench therefore drives carrier sense as a function of its own running bit-tick count, so a one-tick pulse can be placed a computed number of ticks after the end of a busy period. It then measures the tick on which `txEn` first appears against the expected restart or no-restart value. Padding and the FCS are checked at the bit level against a frame image the bench builds on its own.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUIET,
    ST_HOLD,
    ST_PRE,
    ST_DATA,
    ST_PAD,
    ST_FCS,
    ST_END
  } txState_t;

  // strobes from control to datapath, already qualified by the bit tick
  typedef struct packed {
    logic sendBit;
    logic crcRun;
    logic fcsMode;
    logic loadPre;
    logic loadSfd;
    logic loadData;
    logic loadPad;
    logic frameInit;
    logic endFrame;
  } dpCtl_t;

  localparam logic [7:0]  PRE_BYTE  = 8'h55;
  localparam logic [7:0]  SFD_BYTE  = 8'hD5;
  localparam logic [31:0] CRC_REFL  = 32'hEDB88320;
  localparam int          FCS_BITS  = 32;

endpackage

// File: rtl/ethtx_datapath.sv
module ethtx_datapath
  import ethtx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [7:0]       inData,
  output logic             byteEnd,
  output logic [LEN_W-1:0] byteCnt,
  output logic             txData,
  output logic             txEn,
  output logic             frameDone
);

  logic [7:0]  curByte;
  logic [2:0]  bitIdx;
  logic [31:0] crcReg;
  logic [31:0] crcNext;
  logic        curBit;
  logic        feedBack;

  assign curBit   = curByte[bitIdx];
  assign byteEnd  = (bitIdx == 3'd7);
  assign feedBack = crcReg[0] ^ curBit;
  assign crcNext  = {1'b0, crcReg[31:1]} ^ (feedBack ? CRC_REFL : 32'h0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curByte   <= '0;
      bitIdx    <= '0;
      crcReg    <= '1;
      byteCnt   <= '0;
      txData    <= 1'b0;
      txEn      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= ctl.endFrame;
      if (ctl.frameInit) begin
        crcReg  <= '1;
        bitIdx  <= '0;
        byteCnt <= '0;
      end
      if (ctl.sendBit) begin
        txEn <= 1'b1;
        if (ctl.fcsMode) begin
          txData <= ~crcReg[0];
          crcReg <= {1'b0, crcReg[31:1]};
        end else begin
          txData <= curBit;
          bitIdx <= bitIdx + 3'd1;
          if (ctl.crcRun) crcReg <= crcNext;
        end
      end
      if (ctl.loadPre)  curByte <= PRE_BYTE;
      if (ctl.loadSfd)  curByte <= SFD_BYTE;
      if (ctl.loadData) curByte <= inData;
      if (ctl.loadPad)  curByte <= 8'h00;
      if (ctl.loadData || ctl.loadPad) byteCnt <= byteCnt + LEN_W'(1);
      if (ctl.endFrame) begin
        txEn   <= 1'b0;
        txData <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ethtx_ctrl.sv
module ethtx_ctrl
  import ethtx_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int QUIET_TICKS = 60,
  parameter int HOLD_TICKS  = 36,
  parameter int PRE_BYTES   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             inValid,
  input  logic             inLast,
  input  logic             inPad,
  input  logic             inCrc,
  input  logic             carrierSense,
  input  logic [LEN_W-1:0] minLen,
  input  logic             byteEnd,
  input  logic [LEN_W-1:0] byteCnt,
  output logic             inReady,
  output dpCtl_t           ctl
);

  localparam int BIG     = (QUIET_TICKS > HOLD_TICKS) ? QUIET_TICKS : HOLD_TICKS;
  localparam int TMR_MAX = (BIG > FCS_BITS) ? BIG : FCS_BITS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PRE_W   = $clog2(PRE_BYTES + 1);

  txState_t         state, stateNext;
  logic [TMR_W-1:0] timer, timerNext;
  logic [PRE_W-1:0] preCnt, preCntNext;
  logic             lastQ, padQ, crcQ;
  logic             needPad;

  assign needPad = byteCnt < minLen;

  always_comb begin
    stateNext  = state;
    timerNext  = timer;
    preCntNext = preCnt;
    ctl        = '0;
    inReady    = 1'b0;
    if (bitEn) begin
      unique case (state)
        ST_IDLE: if (inValid) begin
          stateNext = ST_QUIET;
          timerNext = '0;
        end
        ST_QUIET: begin
          if (carrierSense) timerNext = '0;
          else if (timer == TMR_W'(QUIET_TICKS - 1)) begin
            stateNext = ST_HOLD;
            timerNext = '0;
          end else timerNext = timer + TMR_W'(1);
        end
        ST_HOLD: begin
          if (timer == TMR_W'(HOLD_TICKS - 1)) begin
            stateNext     = ST_PRE;
            preCntNext    = '0;
            ctl.loadPre   = 1'b1;
            ctl.frameInit = 1'b1;
          end else timerNext = timer + TMR_W'(1);
        end
        ST_PRE: begin
          ctl.sendBit = 1'b1;
          if (byteEnd) begin
            preCntNext = preCnt + PRE_W'(1);
            if (preCnt == PRE_W'(PRE_BYTES)) begin
              stateNext    = ST_DATA;
              ctl.loadData = 1'b1;
              inReady      = 1'b1;
            end else if (preCnt == PRE_W'(PRE_BYTES - 1)) ctl.loadSfd = 1'b1;
            else ctl.loadPre = 1'b1;
          end
        end
        ST_DATA, ST_PAD: begin
          ctl.sendBit = 1'b1;
          ctl.crcRun  = 1'b1;
          if (byteEnd) begin
            if (state == ST_DATA && !lastQ) begin
              ctl.loadData = 1'b1;
              inReady      = 1'b1;
            end else if ((state == ST_PAD || padQ) && needPad) begin
              stateNext   = ST_PAD;
              ctl.loadPad = 1'b1;
            end else if (crcQ) begin
              stateNext = ST_FCS;
              timerNext = '0;
            end else stateNext = ST_END;
          end
        end
        ST_FCS: begin
          ctl.sendBit = 1'b1;
          ctl.fcsMode = 1'b1;
          if (timer == TMR_W'(FCS_BITS - 1)) stateNext = ST_END;
          else timerNext = timer + TMR_W'(1);
        end
        ST_END: begin
          ctl.endFrame = 1'b1;
          stateNext    = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      preCnt <= '0;
      lastQ  <= 1'b0;
      padQ   <= 1'b0;
      crcQ   <= 1'b0;
    end else begin
      state  <= stateNext;
      timer  <= timerNext;
      preCnt <= preCntNext;
      if (inReady && inValid) begin
        lastQ <= inLast;
        padQ  <= inPad;
        crcQ  <= inCrc;
      end
    end
  end

endmodule

// File: rtl/eth_tx_formatter.sv
module eth_tx_formatter
  import ethtx_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int QUIET_TICKS = 60,
  parameter int HOLD_TICKS  = 36,
  parameter int PRE_BYTES   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inLast,
  input  logic             inPad,
  input  logic             inCrc,
  input  logic             carrierSense,
  input  logic [LEN_W-1:0] minLen,
  output logic             txData,
  output logic             txEn,
  output logic             frameDone
);

  dpCtl_t           ctl;
  logic             byteEnd;
  logic [LEN_W-1:0] byteCnt;

  ethtx_ctrl #(
    .LEN_W(LEN_W), .QUIET_TICKS(QUIET_TICKS),
    .HOLD_TICKS(HOLD_TICKS), .PRE_BYTES(PRE_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inValid(inValid),
    .inLast(inLast), .inPad(inPad), .inCrc(inCrc),
    .carrierSense(carrierSense), .minLen(minLen),
    .byteEnd(byteEnd), .byteCnt(byteCnt),
    .inReady(inReady), .ctl(ctl)
  );

  ethtx_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .byteEnd(byteEnd), .byteCnt(byteCnt),
    .txData(txData), .txEn(txEn), .frameDone(frameDone)
  );

endmodule

// File: rtl/ethtx_checker.sv
module ethtx_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic inReady,
  input logic txData,
  input logic txEn,
  input logic frameDone
);

  // R12: the wire only moves on a bit tick
  assert_wire_on_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(txEn) && $stable(txData)));

  // R11: a byte is only requested on a bit tick
  assert_ready_on_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> bitEn);

  // R10: completion is a single-clock pulse
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R10: completion coincides with enable falling
  assert_done_at_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEn) |-> frameDone);

  // R10: no completion pulse while still transmitting
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !txEn);

endmodule

bind eth_tx_formatter ethtx_checker u_checker (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .inReady(inReady),
  .txData(txData), .txEn(txEn), .frameDone(frameDone)
);

// File: tb/test_eth_tx_formatter.sv
`timescale 1ns/1ps
module test_eth_tx_formatter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        inLast = 1'b0;
  logic        inPad = 1'b0;
  logic        inCrc = 1'b0;
  logic        carrierSense = 1'b0;
  logic [10:0] minLen = 11'd60;
  logic        txData, txEn, frameDone;

  always #2.5 clk = ~clk;

  eth_tx_formatter i_eth_tx_formatter (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inData(inData),
    .inValid(inValid), .inReady(inReady), .inLast(inLast),
    .inPad(inPad), .inCrc(inCrc), .carrierSense(carrierSense),
    .minLen(minLen), .txData(txData), .txEn(txEn), .frameDone(frameDone)
  );

  typedef struct packed {
    logic [10:0] len;
    logic        pad;
    logic        crc;
    logic [10:0] minv;
  } vec_t;

  // length, pad flag, crc flag, minimum
  localparam vec_t VECS [0:8] = '{
    '{11'd64, 1'b1, 1'b1, 11'd60},
    '{11'd20, 1'b1, 1'b1, 11'd60},
    '{11'd20, 1'b0, 1'b1, 11'd60},
    '{11'd20, 1'b1, 1'b0, 11'd60},
    '{11'd1,  1'b1, 1'b1, 11'd60},
    '{11'd59, 1'b1, 1'b1, 11'd60},
    '{11'd60, 1'b1, 1'b1, 11'd60},
    '{11'd30, 1'b1, 1'b1, 11'd40},
    '{11'd5,  1'b0, 1'b0, 11'd60}
  };

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  int tickNum = 0, phase = 0;
  int csHigh = 0, csPulse = -1;
  int srcIdx = 0, srcLen = 0, srcSeed = 0;
  bit advancePending = 0;
  bit capBits [0:1023];
  int capLen = 0, startTick = 0, doneCount = 0;
  bit expBits [0:1023];
  int expLen = 0, bodyEnd = 0;

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 37) + (seed * 11) + 3);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic void updateSrc();
    inValid = (srcIdx < srcLen);
    inData  = pat(srcSeed, srcIdx);
    inLast  = (srcIdx == srcLen - 1);
  endfunction

  // single driver/monitor process, active at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (advancePending) begin
        srcIdx++;
        updateSrc();
      end
      if (bitEn) begin
        tickNum++;
        if (txEn) begin
          if (capLen == 0) startTick = tickNum;
          if (capLen < 1024) capBits[capLen] = txData;
          capLen++;
        end
        if (frameDone) doneCount++;
      end
      bitEn = (phase == 3);
      phase = (phase + 1) % 4;
      carrierSense = ((tickNum + 1) <= csHigh) || ((tickNum + 1) == csPulse);
      #2;
      advancePending = inValid && inReady;
    end
  end

  task automatic buildExp(input int len, input bit pad, input bit crc, input int minv, input int seed);
    int n;
    logic [31:0] c;
    logic [7:0] b;
    expLen = 0;
    for (int k = 0; k < 8; k++) begin
      b = (k == 7) ? 8'hD5 : 8'h55;
      for (int j = 0; j < 8; j++) begin expBits[expLen] = b[j]; expLen++; end
    end
    n = (pad && len < minv) ? minv : len;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      b = (i < len) ? pat(seed, i) : 8'h00;
      for (int j = 0; j < 8; j++) begin
        expBits[expLen] = b[j];
        expLen++;
        c = (c[0] ^ b[j]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    end
    bodyEnd = expLen;
    if (crc) begin
      c = ~c;
      for (int j = 0; j < 32; j++) begin expBits[expLen] = c[j]; expLen++; end
    end
  endtask

  task automatic sendFrame(input int len, input bit pad, input bit crc, input int minv, input int seed);
    int d0;
    @(negedge clk);
    #0.5;
    d0 = doneCount;
    capLen = 0;
    minLen = 11'(minv);
    inPad = pad;
    inCrc = crc;
    srcSeed = seed;
    srcLen = len;
    srcIdx = 0;
    updateSrc();
    wait (doneCount != d0);
    repeat (12) @(negedge clk);
  endtask

  task automatic compareFrame(input string bodyTag, input string lenTag, input bit crc);
    int bad;
    bad = 0;
    for (int i = 0; i < 64; i++) if (capBits[i] != expBits[i]) bad++;
    chk(bad == 0, "R2 preamble/delimiter bit errors", bad, 0);
    bad = 0;
    for (int i = 64; i < bodyEnd; i++) if (capBits[i] != expBits[i]) bad++;
    chk(bad == 0, {bodyTag, " frame body bit errors"}, bad, 0);
    chk(capLen == expLen, {lenTag, " bits while txEn high"}, capLen, expLen);
    if (crc) begin
      bad = 0;
      for (int i = bodyEnd; i < expLen && i < 1024; i++) if (capBits[i] != expBits[i]) bad++;
      chk(bad == 0, "R9 FCS bit errors", bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!txEn && !txData && !frameDone && !inReady, "R1 outputs during reset",
        {txEn, txData, frameDone, inReady}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk(!txEn && !txData && !frameDone && !inReady, "R1 outputs after reset",
        {txEn, txData, frameDone, inReady}, 0);

    foreach (VECS[v]) begin
      string bt, lt;
      int dBefore;
      dBefore = doneCount;
      buildExp(VECS[v].len, VECS[v].pad, VECS[v].crc, VECS[v].minv, v);
      sendFrame(VECS[v].len, VECS[v].pad, VECS[v].crc, VECS[v].minv, v);
      bt = (VECS[v].pad && VECS[v].len < VECS[v].minv) ? "R7" : "R3";
      lt = (VECS[v].pad && VECS[v].len < VECS[v].minv) ? "R7" :
           (VECS[v].crc ? "R9" : "R8");
      compareFrame(bt, lt, VECS[v].crc);
      chk(doneCount == dBefore + 1, "R10 done pulses per frame", doneCount - dBefore, 1);
      chk(!txEn, "R10 txEn low after frame", txEn, 0);
    end

    // R4: deferral after a busy period
    begin
      int rel;
      @(negedge clk);
      csHigh = tickNum + 20;
      csPulse = -1;
      rel = csHigh;
      sendFrame(4, 1'b0, 1'b0, 60, 21);
      chk(startTick == rel + 97, "R4 start tick after carrier release", startTick - rel, 97);
    end
    // R5: pulse in quiet phase restarts the count
    begin
      int p;
      @(negedge clk);
      csHigh = tickNum + 20;
      csPulse = csHigh + 30;
      p = csPulse;
      sendFrame(4, 1'b0, 1'b0, 60, 22);
      chk(startTick == p + 97, "R5 start tick after quiet-phase pulse", startTick - p, 97);
    end
    // R6: pulse in hold phase is ignored
    begin
      int rel;
      @(negedge clk);
      csHigh = tickNum + 20;
      csPulse = csHigh + 70;
      rel = csHigh;
      sendFrame(4, 1'b0, 1'b0, 60, 23);
      chk(startTick == rel + 97, "R6 start tick with hold-phase pulse", startTick - rel, 97);
    end
    // R11: exactly as many bytes taken as offered
    chk(srcIdx == 4, "R11 bytes consumed by last frame", srcIdx, 4);
    chk(!inReady, "R11 inReady low when idle", inReady, 0);
    // R12: wire idle between frames
    chk(!txEn && !txData, "R12 wire idle after frames", {txEn, txData}, 0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule